// File: doc/BRIEF.md
# Byte-Port Preset and Latch Counter Axis

This block is one axis of a position counter that sits behind an 8-bit processor bus. It has three wide registers: a preset, an up/down counter and an output latch. All are `CNT_W` bits wide, with a default of 24. An external decoder supplies count-up and count-down enables. The counter moves by one on each enabled cycle and wraps modulo 2^`CNT_W` in both directions.

Wide values cross the 8-bit port one byte per data cycle. A shared byte pointer picks the byte lane, starting with the least significant. Software reads the counter only through the output latch. A control write captures the counter into that latch, so a multi-byte read sees one stable snapshot. Other control writes reset the byte pointer or copy the preset into the counter.

Every bus access lasts exactly one clock cycle in which the strobe is high. The bus has no wait states and no back-pressure: an access that is presented is always taken in that cycle. The port signals are plain strobes, not a valid/ready stream.

Top module: `axis_count_port`

## Requirements
- R1: After reset, the preset, counter and latch are all zero and the byte pointer selects byte 0 (bits 7:0).
- R2: A data write (`cs`=1, `cd`=0, `wr`=1) stores `din` into the preset byte chosen by the pointer. The pointer then advances by one. After byte `CNT_W/8-1` it returns to byte 0.
- R3: A data read (`cs`=1, `cd`=0, `rd`=1, `wr`=0) presents the latch byte chosen by the pointer on `dout` in that same cycle. The pointer then advances and wraps in the same way as in R2.
- R4: `dout_oe` is 1 only during a data read. Whenever `dout_oe` is 0, `dout` is all zeros. A cycle with both `rd` and `wr` high counts as a write.
- R5: A control write (`cs`=1, `cd`=1, `wr`=1) with `din[7:5]`=3'b001 is a command. If its bit 0 is 1, the byte pointer returns to byte 0.
- R6: In a command, bit 1 = 1 loads the counter from the preset at the end of that cycle.
- R7: In a command, bit 2 = 1 copies the counter into the latch. If bits 1 and 2 are both set, the latch receives the counter value from before the load.
- R8: In a cycle with `cnt_up`=1 and `cnt_dn`=0, the counter adds one. With `cnt_dn`=1 and `cnt_up`=0, it subtracts one. Either way it wraps modulo 2^`CNT_W`. With both enables high or both low, the counter holds.
- R9: A load command and a count enable in the same cycle leave the counter equal to the preset.
- R10: The following leave the preset, counter, latch and pointer unchanged: any cycle with `cs`=0, a control write whose `din[7:5]` is not 3'b001, and a control read. A control read also keeps `dout_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| cd | input | 1 | 1 = control access, 0 = data access |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, zero when not enabled |
| dout_oe | output | 1 | Drive enable for the external tri-state bus |
| cnt_up | input | 1 | Count-up enable from the decoder |
| cnt_dn | input | 1 | Count-down enable from the decoder |

## Verification
The bench builds the block with `CNT_W` = 16, which gives two byte lanes. With only two lanes, every pointer position and its wrap come up within a few accesses. A 16-bit counter also lets the bench sweep preset values across the full range, with steps coarse enough to finish quickly. Both wrap directions of the counter are reached by loading values next to the limits. The same cases hold for the 24-bit default, which has three lanes. Expected bytes come from shifting and masking the values the bench itself wrote.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int BYTE_W = 8;
  // command register select in din[7:5]
  localparam logic [2:0] CMD_SEL = 3'b001;
  // flag positions inside a command byte
  localparam int FLG_RST_BP = 0;
  localparam int FLG_LOAD   = 1;
  localparam int FLG_LATCH  = 2;

  typedef struct packed {
    logic rst_bp;
    logic load;
    logic latch;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic valid, input logic [BYTE_W-1:0] b);
    cmd_t c;
    logic hit;
    hit = valid && (b[7:5] == CMD_SEL);
    c.rst_bp = hit && b[FLG_RST_BP];
    c.load   = hit && b[FLG_LOAD];
    c.latch  = hit && b[FLG_LATCH];
    return c;
  endfunction
endpackage

// File: rtl/acp_byte_ptr.sv
module acp_byte_ptr #(
  parameter int NBYTES = 3,
  localparam int BPW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  output logic [BPW-1:0] ptr
);
  localparam logic [BPW-1:0] LAST = BPW'(NBYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)    ptr <= '0;
    else if (step) begin
      if (ptr == LAST)    ptr <= '0;
      else                ptr <= ptr + BPW'(1);
    end
  end
endmodule

// File: rtl/acp_byte_reg.sv
module acp_byte_reg #(
  parameter int NBYTES = 3,
  localparam int W   = NBYTES * 8,
  localparam int BPW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [BPW-1:0] lane,
  input  logic [7:0]     din,
  output logic [W-1:0]   q
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                          q[i*8 +: 8] <= '0;
      else if (we && lane == BPW'(i))      q[i*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/acp_counter.sv
module acp_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (up && !dn)  cnt <= cnt + W'(1);
    else if (dn && !up)  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/axis_count_port.sv
module axis_count_port #(
  parameter int CNT_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       cd,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  input  logic       cnt_up,
  input  logic       cnt_dn
);
  import acp_pkg::*;

  localparam int NB  = CNT_W / BYTE_W;
  localparam int BPW = (NB > 1) ? $clog2(NB) : 1;

  logic             data_wr, data_rd, ctl_wr;
  cmd_t             cmd;
  logic [BPW-1:0]   bp_q;
  logic [CNT_W-1:0] preset_q, cnt_q, latch_q;

  assign data_wr = cs && !cd && wr;
  assign data_rd = cs && !cd && rd && !wr;
  assign ctl_wr  = cs && cd && wr;
  assign cmd     = decode_cmd(ctl_wr, din);

  acp_byte_ptr #(.NBYTES(NB)) u_bp (
    .clk(clk), .rst_n(rst_n), .clr(cmd.rst_bp),
    .step(data_wr || data_rd), .ptr(bp_q)
  );

  acp_byte_reg #(.NBYTES(NB)) u_preset (
    .clk(clk), .rst_n(rst_n), .we(data_wr), .lane(bp_q),
    .din(din), .q(preset_q)
  );

  acp_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cmd.load), .load_val(preset_q),
    .up(cnt_up), .dn(cnt_dn), .cnt(cnt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         latch_q <= '0;
    else if (cmd.latch) latch_q <= cnt_q;
  end

  assign dout_oe = data_rd;
  assign dout    = data_rd ? latch_q[bp_q*8 +: 8] : 8'h00;
endmodule

// File: rtl/axis_count_port_chk.sv
module axis_count_port_chk #(
  parameter int CNT_W = 24,
  parameter int NB = 3,
  parameter int BPW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             cd,
  input logic             rd,
  input logic             wr,
  input logic [7:0]       din,
  input logic [7:0]       dout,
  input logic             dout_oe,
  input logic             cnt_up,
  input logic             cnt_dn,
  input logic [BPW-1:0]   bp,
  input logic [CNT_W-1:0] preset,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] latch
);
  logic cmd_hit;
  assign cmd_hit = cs && cd && wr && din[7:5] == 3'b001;

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !cd && wr && bp == BPW'(NB - 1)) |=> bp == '0);
  // R4
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == 8'h00);
  // R4
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd && !cd && !wr) |-> !dout_oe);
  // R8
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up && !cnt_dn && !(cmd_hit && din[1])) |=> cnt == $past(cnt) + CNT_W'(1));
  // R8
  count_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dn && !cnt_up && !(cmd_hit && din[1])) |=> cnt == $past(cnt) - CNT_W'(1));
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && din[1]) |=> cnt == $past(preset));
  // R7
  latch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && din[2]) |=> latch == $past(cnt));
  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(preset) && $stable(latch) && $stable(bp));
endmodule

bind axis_count_port axis_count_port_chk #(.CNT_W(CNT_W), .NB(NB), .BPW(BPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .cd(cd), .rd(rd), .wr(wr), .din(din),
  .dout(dout), .dout_oe(dout_oe), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
  .bp(bp_q), .preset(preset_q), .cnt(cnt_q), .latch(latch_q)
);

// File: tb/sim_axis_count_port.sv
module sim_axis_count_port;
  localparam int W = 16;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 0, rst_n = 0;
  logic cs = 0, cd = 0, rd = 0, wr = 0, cnt_up = 0, cnt_dn = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic dout_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  axis_count_port #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .cd(cd), .rd(rd), .wr(wr), .din(din),
    .dout(dout), .dout_oe(dout_oe), .cnt_up(cnt_up), .cnt_dn(cnt_dn)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 0; cd = 0; rd = 0; wr = 0; din = 0; cnt_up = 0; cnt_dn = 0;
  endtask

  task automatic bus_wr(input logic c, input logic [7:0] d, input logic up = 0);
    @(negedge clk);
    cs = 1; cd = c; wr = 1; rd = 0; din = d; cnt_up = up;
    idle();
  endtask

  task automatic bus_rd(input logic c, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs = 1; cd = c; rd = 1; wr = 0;
    #2 d = dout; oe = dout_oe;
    idle();
  endtask

  task automatic set_preset(input logic [W-1:0] v);
    bus_wr(0, v[7:0]);
    bus_wr(0, v[15:8]);
  endtask

  task automatic read_latch(output logic [W-1:0] v);
    logic [7:0] b0, b1;
    logic oe;
    bus_wr(1, 8'h21);
    bus_rd(0, b0, oe);
    bus_rd(0, b1, oe);
    v = {b1, b0};
  endtask

  task automatic snap(output logic [W-1:0] v);
    bus_wr(1, 8'h24);
    read_latch(v);
  endtask

  task automatic count(input logic u, input logic dn, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_up = u; cnt_dn = dn;
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b, b2;
    logic oe;
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: latch zero, pointer at byte 0
    bus_rd(0, b, oe); chk("R1 byte0", b, 0); chk("R3 oe during read", oe, 1);
    bus_rd(0, b, oe); chk("R1 byte1", b, 0);
    snap(v); chk("R1 counter zero", v, 0);

    // R6 R3 R2: sweep preset values through load/latch/read
    for (int k = 0; k < 65536; k += 251) begin
      bus_wr(1, 8'h21);
      set_preset(W'(k));
      bus_wr(1, 8'h22);
      snap(v);
      chk("R6 load sweep", v, k);
    end

    // R2: third write wraps to byte 0
    bus_wr(1, 8'h21);
    bus_wr(0, 8'h11); bus_wr(0, 8'h22); bus_wr(0, 8'h33);
    bus_wr(1, 8'h22); snap(v); chk("R2 write wrap", v, 16'h2233);

    // R3: third read wraps to byte 0 ; R5 reset pointer mid-sequence
    bus_wr(1, 8'h21);
    bus_rd(0, b, oe); bus_rd(0, b, oe); bus_rd(0, b, oe);
    chk("R3 read wrap", b, 8'h33);
    bus_wr(1, 8'h21); bus_rd(0, b, oe); chk("R5 ptr reset", b, 8'h33);

    // R4: idle and rd+wr keep oe low
    @(negedge clk); #2 chk("R4 idle oe", dout_oe, 0); chk("R4 idle dout", dout, 0);
    @(negedge clk); cs = 1; rd = 1; wr = 1; cd = 1; din = 8'h00;
    #2 chk("R4 rd+wr oe", dout_oe, 0);
    idle();

    // R8: up wrap, down wrap, both-high hold
    bus_wr(1, 8'h21); set_preset(16'hFFFE); bus_wr(1, 8'h22);
    count(1, 0, 3); snap(v); chk("R8 up wrap", v, (16'hFFFE + 3) & MASK);
    count(0, 1, 3); snap(v); chk("R8 down wrap", v, 16'hFFFE);
    count(1, 1, 5); snap(v); chk("R8 both hold", v, 16'hFFFE);
    count(0, 0, 5); snap(v); chk("R8 none hold", v, 16'hFFFE);

    // R9: load with count up same cycle
    bus_wr(1, 8'h21); set_preset(16'h1234);
    bus_wr(1, 8'h22, 1); snap(v); chk("R9 load priority", v, 16'h1234);

    // R7: load+latch together captures pre-load value
    count(1, 0, 2);
    bus_wr(1, 8'h21); set_preset(16'h0777);
    bus_wr(1, 8'h26);
    read_latch(v); chk("R7 latch old value", v, 16'h1236);
    snap(v); chk("R6 loaded after combo", v, 16'h0777);

    // R10: cs low, other fields, control read
    @(negedge clk); cs = 0; wr = 1; cd = 0; din = 8'hAA; idle();
    @(negedge clk); cs = 0; wr = 1; cd = 1; din = 8'h26; idle();
    bus_wr(1, 8'h42); bus_wr(1, 8'hE6);
    bus_rd(1, b, oe); chk("R10 ctl read oe", oe, 0);
    bus_wr(1, 8'h22); snap(v); chk("R10 state kept", v, 16'h0777);
    bus_wr(1, 8'h21); bus_rd(0, b, oe);
    bus_rd(1, b2, oe);
    bus_rd(0, b, oe); chk("R10 ctl read no ptr step", b, 8'h07);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule